// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer arithmetic and logic stage of a small processor core. In each cycle it takes a one-byte opcode, the three-bit sub-opcode from the reg field of the operand descriptor, a register operand and a second operand that comes from either a register or memory. It returns a result and a write-back enable. It also returns a destination select, which tells the write-back path whether the result belongs in the register operand or in the register/memory operand. Operand fetch and address generation happen upstream. The write-back itself happens downstream.

The block recognises add, subtract, compare, AND, OR, XOR and bitwise NOT. The arithmetic group computes carry and overflow separately: carry is the unsigned carry or borrow, and overflow is the signed overflow. Compare does the subtraction but only updates the flags. The logical operations always clear carry and overflow. NOT writes its result and leaves the flags alone.

The four flags (sign, zero, carry, overflow) sit in a register. They change on the clock edge at which a valid, flag-setting operation is presented. Everything else is combinational, so a new operation can be accepted every cycle and there is no back-pressure. The `op_valid` pin only qualifies the present cycle.

Top module: `alu_flags_unit`

## Requirements
- R1: A two-operand operation is decoded when opcode bits [7:6] are 00, bit 2 is 0 and bit 0 is 1. Bits [5:3] then select the operation: 000 add, 001 OR, 100 AND, 101 subtract, 110 XOR, 111 compare. Opcode 0xF7 with sub-opcode 2 is NOT. Every other opcode and sub-opcode pair is illegal, including bits [5:3] equal to 010 or 011 and 0xF7 with any other sub-opcode.
- R2: For two-operand operations, opcode bit 1 sets the operand roles. When bit 1 is 0, the left operand is the register/memory operand, the right operand is the register, and `wb_to_reg` is 0. When bit 1 is 1, the left operand is the register, the right operand is the register/memory operand, and `wb_to_reg` is 1.
- R3: Add returns (left + right) mod 2^W. CF is the unsigned carry out of the top bit, OF is two's-complement overflow, SF is the top result bit and ZF is set when the result is zero. For example, 0x7fffffff + 1 gives 0x80000000 with SF=1, ZF=0, CF=0, OF=1.
- R4: Subtract returns (left − right) mod 2^W. CF is set when left < right as unsigned values (borrow), OF is two's-complement overflow, and SF and ZF follow the result. For example, 0 − 0x80000000 gives 0x80000000 with SF=1, ZF=0, CF=1, OF=1.
- R5: Compare sets the four flags exactly as subtract does and keeps `wb_en` low.
- R6: AND, OR and XOR return the bitwise result. SF is the top result bit, ZF is set when the result is zero, and CF and OF are cleared.
- R7: NOT returns the bitwise complement of the register/memory operand, with `wb_en`=1 and `wb_to_reg`=0. The flags are unchanged.
- R8: The flags load on the rising clock edge when `op_valid` is high and the operation sets flags. When `op_valid` is low, `wb_en` and `illegal` are 0 and the flags hold.
- R9: An illegal operation with `op_valid` high drives `illegal`=1 and `wb_en`=0, and the flags hold.
- R10: After reset all four flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Marks the present inputs as an operation to execute |
| opcode | input | 8 | Primary opcode byte |
| subop | input | 3 | Sub-opcode from the descriptor reg field |
| reg_opnd | input | W | Register operand |
| rm_opnd | input | W | Register/memory operand |
| result | output | W | Operation result |
| wb_en | output | 1 | Result is to be written back |
| wb_to_reg | output | 1 | 1: write to the register operand, 0: write to the register/memory operand |
| illegal | output | 1 | Valid opcode outside the supported set |
| sign_f | output | 1 | Registered sign flag |
| zero_f | output | 1 | Registered zero flag |
| carry_f | output | 1 | Registered carry/borrow flag |
| ovf_f | output | 1 | Registered signed overflow flag |

## Verification
The bench builds the unit with W=8. At that width every pair of operands can be swept for add and for subtract in about 131k cycles, so every carry, borrow and signed-overflow boundary is reached, not just a sampled few. A strided operand sweep then runs all twelve two-operand opcodes in both operand orders. The remaining sweeps cover all 256 opcode values, every sub-opcode under 0xF7, and every NOT operand. Expected results and flags come from integer arithmetic in the bench, with the flag state tracked across operations, so any write to a flag that should hold is caught.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_SUB, K_XOR, K_CMP, K_NOT, K_BAD
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      to_reg;
    logic      writes;
    logic      sets_flags;
    logic      legal;
  } alu_ctl_t;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic o;
  } alu_flags_t;

  localparam logic [7:0] OPC_UNARY = 8'hF7;
  localparam logic [2:0] SUB_NOT   = 3'd2;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [2:0] subop,
  output alu_ctl_t   ctl
);
  logic two_opnd_form;
  assign two_opnd_form = (opcode[7:6] == 2'b00) && !opcode[2] && opcode[0];

  always_comb begin
    ctl = '{kind: K_BAD, to_reg: 1'b0, writes: 1'b0, sets_flags: 1'b0, legal: 1'b0};
    if (two_opnd_form) begin
      ctl.to_reg     = opcode[1];
      ctl.legal      = 1'b1;
      ctl.writes     = 1'b1;
      ctl.sets_flags = 1'b1;
      case (opcode[5:3])
        3'd0: ctl.kind = K_ADD;
        3'd1: ctl.kind = K_OR;
        3'd4: ctl.kind = K_AND;
        3'd5: ctl.kind = K_SUB;
        3'd6: ctl.kind = K_XOR;
        3'd7: begin
          ctl.kind   = K_CMP;
          ctl.writes = 1'b0;
        end
        default: ctl = '{kind: K_BAD, to_reg: 1'b0, writes: 1'b0,
                         sets_flags: 1'b0, legal: 1'b0};
      endcase
    end else if (opcode == OPC_UNARY && subop == SUB_NOT) begin
      ctl.kind   = K_NOT;
      ctl.legal  = 1'b1;
      ctl.writes = 1'b1;
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_kind_e    kind,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res,
  output alu_flags_t   nf
);
  localparam int MSB = W - 1;

  logic [W:0] sum_x;
  logic [W:0] dif_x;
  assign sum_x = {1'b0, lhs} + {1'b0, rhs};
  assign dif_x = {1'b0, lhs} - {1'b0, rhs};

  logic [W-1:0] r;
  logic         cy, ov;

  always_comb begin
    cy = 1'b0;
    ov = 1'b0;
    case (kind)
      K_ADD: begin
        r  = sum_x[MSB:0];
        cy = sum_x[W];
        ov = (lhs[MSB] == rhs[MSB]) && (sum_x[MSB] != lhs[MSB]);
      end
      K_SUB, K_CMP: begin
        r  = dif_x[MSB:0];
        cy = dif_x[W];
        ov = (lhs[MSB] != rhs[MSB]) && (dif_x[MSB] != lhs[MSB]);
      end
      K_AND:   r = lhs & rhs;
      K_OR:    r = lhs | rhs;
      K_XOR:   r = lhs ^ rhs;
      K_NOT:   r = ~lhs;
      default: r = '0;
    endcase
  end

  assign res  = r;
  assign nf.s = r[MSB];
  assign nf.z = (r == '0);
  assign nf.c = cy;
  assign nf.o = ov;
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  alu_flags_t d,
  output alu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [7:0]   opcode,
  input  logic [2:0]   subop,
  input  logic [W-1:0] reg_opnd,
  input  logic [W-1:0] rm_opnd,
  output logic [W-1:0] result,
  output logic         wb_en,
  output logic         wb_to_reg,
  output logic         illegal,
  output logic         sign_f,
  output logic         zero_f,
  output logic         carry_f,
  output logic         ovf_f
);
  alu_ctl_t     ctl;
  alu_flags_t   nxt_flags, flags_q;
  logic [W-1:0] lhs, rhs;

  alu_decode u_dec (.opcode(opcode), .subop(subop), .ctl(ctl));

  assign lhs = ctl.to_reg ? reg_opnd : rm_opnd;
  assign rhs = ctl.to_reg ? rm_opnd  : reg_opnd;

  alu_core #(.W(W)) u_core (.kind(ctl.kind), .lhs(lhs), .rhs(rhs),
                            .res(result), .nf(nxt_flags));

  alu_flag_reg u_flags (.clk(clk), .rst_n(rst_n),
                        .load(op_valid && ctl.sets_flags),
                        .d(nxt_flags), .q(flags_q));

  assign wb_en     = op_valid && ctl.writes;
  assign wb_to_reg = ctl.to_reg;
  assign illegal   = op_valid && !ctl.legal;
  assign sign_f    = flags_q.s;
  assign zero_f    = flags_q.z;
  assign carry_f   = flags_q.c;
  assign ovf_f     = flags_q.o;

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({sign_f, zero_f, carry_f, ovf_f}));

  assert_illegal_nowb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);

  assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable({sign_f, zero_f, carry_f, ovf_f}));

  assert_cmp_nowb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 8'h39 || opcode == 8'h3B)) |-> (!wb_en && !illegal));

  assert_not_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'hF7 && subop == 3'd2)
      |=> $stable({sign_f, zero_f, carry_f, ovf_f}));

  assert_logic_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 8'h21 || opcode == 8'h23 || opcode == 8'h09 ||
                  opcode == 8'h0B || opcode == 8'h31 || opcode == 8'h33))
      |=> (!carry_f && !ovf_f));
endmodule

// File: tb/alu_flags_unit_test.sv
module alu_flags_unit_test;
  localparam int BW = 8;
  localparam int M  = 1 << BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [7:0]    opcode = '0;
  logic [2:0]    subop = '0;
  logic [BW-1:0] reg_opnd = '0, rm_opnd = '0;
  logic [BW-1:0] result;
  logic          wb_en, wb_to_reg, illegal, sign_f, zero_f, carry_f, ovf_f;

  always #4 clk = ~clk;

  alu_flags_unit #(.W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .subop(subop),
    .reg_opnd(reg_opnd), .rm_opnd(rm_opnd), .result(result), .wb_en(wb_en),
    .wb_to_reg(wb_to_reg), .illegal(illegal), .sign_f(sign_f), .zero_f(zero_f),
    .carry_f(carry_f), .ovf_f(ovf_f));

  int n_tot = 0, n_bad = 0;
  bit done = 0;

  int    e_res, e_wb, e_toreg, e_ill, e_upd;
  int    n_s, n_z, n_c, n_o;
  logic [3:0] ef = 4'b0;
  string tag;

  task automatic chk(string rq, string what, int act, int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int sgn(int v);
    return (v >= M / 2) ? v - M : v;
  endfunction

  task automatic model(int opc, int sb, int r, int m, bit v);
    int grp, dir, l, rr, full, sf;
    e_res = 0; e_wb = 0; e_toreg = 0; e_ill = 0; e_upd = 0;
    n_s = 0; n_z = 0; n_c = 0; n_o = 0;
    grp = (opc >> 3) & 7;
    if ((opc >> 6) == 0 && ((opc >> 2) & 1) == 0 && (opc & 1) == 1 &&
        grp != 2 && grp != 3) begin
      dir = (opc >> 1) & 1;                 // R2 operand roles
      l  = dir ? r : m;
      rr = dir ? m : r;
      case (grp)
        0: begin
          tag = "R3"; full = l + rr; e_res = full % M; n_c = (full >= M);
          sf = sgn(l) + sgn(rr); n_o = (sf > M / 2 - 1) || (sf < -M / 2);
        end
        5, 7: begin
          tag = (grp == 5) ? "R4" : "R5";
          e_res = (l - rr + M) % M; n_c = (l < rr);
          sf = sgn(l) - sgn(rr); n_o = (sf > M / 2 - 1) || (sf < -M / 2);
        end
        1: begin tag = "R6"; e_res = l | rr; end
        4: begin tag = "R6"; e_res = l & rr; end
        default: begin tag = "R6"; e_res = l ^ rr; end
      endcase
      n_s = (e_res >= M / 2); n_z = (e_res == 0);
      e_wb = (grp != 7); e_upd = 1; e_toreg = dir;
    end else if (opc == 'hF7 && sb == 2) begin
      tag = "R7"; e_res = (~m) & (M - 1); e_wb = 1;
    end else begin
      tag = "R1"; e_ill = 1;
    end
    if (!v) begin
      tag = "R8"; e_ill = 0; e_wb = 0; e_upd = 0;
    end
  endtask

  task automatic run_op(int opc, int sb, int r, int m, bit v);
    model(opc, sb, r, m, v);
    @(negedge clk);
    op_valid = v; opcode = opc[7:0]; subop = sb[2:0];
    reg_opnd = r[BW-1:0]; rm_opnd = m[BW-1:0];
    #1;
    chk(tag, "illegal", int'(illegal), e_ill);
    chk(e_ill ? "R9" : tag, "wb_en", int'(wb_en), e_wb);
    if (e_wb != 0) begin
      chk(tag, "result", int'(result), e_res);
      chk("R2", "wb_to_reg", int'(wb_to_reg), e_toreg);
    end
    @(posedge clk); #1;
    if (e_upd != 0) ef = {n_s[0], n_z[0], n_c[0], n_o[0]};
    chk(e_ill ? "R9" : tag, "flags szco", int'({sign_f, zero_f, carry_f, ovf_f}), int'(ef));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int ops2[12] = '{'h01, 'h03, 'h29, 'h2B, 'h21, 'h23, 'h09, 'h0B, 'h31, 'h33, 'h39, 'h3B};
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset flags", int'({sign_f, zero_f, carry_f, ovf_f}), 0);
    rst_n = 1'b1;
    // directed corners scaled to the bench width
    run_op('h03, 0, 'h7F, 'h01, 1);   // R3 signed overflow
    chk("R3", "0x7f+1 szco", int'({sign_f, zero_f, carry_f, ovf_f}), 'b1001);
    run_op('h03, 0, 'hFF, 'h01, 1);   // R3 carry, zero
    chk("R3", "0xff+1 szco", int'({sign_f, zero_f, carry_f, ovf_f}), 'b0110);
    run_op('h2B, 0, 'h00, 'h80, 1);   // R4 borrow and overflow
    chk("R4", "0-0x80 szco", int'({sign_f, zero_f, carry_f, ovf_f}), 'b1011);
    run_op('h39, 0, 'h05, 'h05, 1);   // R5 compare equal
    run_op('hF7, 2, 'h00, 'h0F, 1);   // R7 not keeps flags
    run_op('h01, 0, 'h7F, 'h01, 0);   // R8 not valid
    run_op('h11, 0, 'h7F, 'h01, 1);   // R9 illegal group
    // exhaustive add and subtract
    for (int a = 0; a < M; a++)
      for (int b = 0; b < M; b++) begin
        run_op('h03, 0, a, b, 1);
        run_op('h2B, 0, a, b, 1);
      end
    // strided sweep of all two-operand opcodes
    for (int k = 0; k < 12; k++)
      for (int a = 0; a < M; a += 17)
        for (int b = 0; b < M; b += 17)
          run_op(ops2[k], 0, a, b, 1);
    for (int a = 0; a < M; a++) run_op('hF7, 2, 'h33, a, 1);
    for (int o = 0; o < 256; o++) run_op(o, 2, (o * 7) % M, (o * 13) % M, 1);
    for (int s = 0; s < 8; s++) run_op('hF7, s, 'h55, 'hA5, 1);
    for (int k = 0; k < 12; k++) run_op(ops2[k], 0, 'h80, 'h80, 0);
    finish_run();
  end
endmodule